// File: doc/BRIEF.md
# Ping-Pong Buffer Read Sequencer

This block feeds a transmit serializer from two memory buffers used in turn. Before the stream starts, software provides a base address for each buffer and one byte count that both buffers share. Once the transmit enable is set, the sequencer reads the first buffer (buffer A) one 32-bit word at a time through a request/grant memory port. It then hands each word to the serializer over a valid/ready handshake. When the last word of a buffer is taken, the sequencer marks that buffer empty and moves on to the other buffer. The two buffers alternate for as long as the enable stays high.

Each buffer has an active flag, an empty flag and an interrupt request that can be masked. Software refills an empty buffer and then pulses that buffer's acknowledge input, which hands the buffer back to the hardware. A buffer that has not been acknowledged is never read a second time. If the sequencer arrives at a buffer that is still marked empty, it waits there and raises a sticky underrun flag. It does not replay old data. The buffer byte count must be a non-zero multiple of 64.

Top module: `pingpong_seq`

## Requirements
- R1: After reset, rd_req, tx_valid, both active flags, both empty flags, underrun and both interrupt requests are 0.
- R2: After tx_enable rises, the first word read and delivered is at base_addr_a offset 0. Later words follow at offsets that step by 4 bytes, and each delivered word equals the memory word at its address.
- R3: A buffer holds buf_bytes/4 words. In the cycle after its last word is accepted on the tx port, its active flag is 0 and its empty flag is 1. A buffer is never active and empty at the same time.
- R4: After buffer A is used up, reading continues at base_addr_b offset 0. After buffer B is used up, it goes back to base_addr_a offset 0. The pattern repeats while tx_enable stays 1.
- R5: irq_a is 1 exactly when empty_a and irq_en_a are both 1. irq_b follows the same rule with empty_b and irq_en_b.
- R6: A 1 on ack_a for one cycle makes empty_a and irq_a 0 from the next clock edge. ack_b does the same for buffer B. When the same buffer's empty flag is set in that same cycle, the set takes priority.
- R7: When the next buffer is still empty, the sequencer issues no read request and no tx_valid, and it sets underrun. Once that buffer is acknowledged, it resumes at offset 0 of that buffer.
- R8: underrun stays 1 while tx_enable is 1 and clears when tx_enable is 0.
- R9: With tx_enable at 0, the following cycle shows both active flags at 0 and no rd_req or tx_valid. The empty flags change only through an acknowledge. The next enable starts again at base_addr_a offset 0.
- R10: While rd_req is 1 and rd_gnt is 0, rd_req and rd_addr hold. A new request is granted only after the previous word has been delivered, so at most one read is outstanding. Read data is valid in the cycle after the grant.
- R11: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmit enable; 0 stops and rewinds the sequencer |
| base_addr_a | input | ADDR_W | Byte base address of buffer A |
| base_addr_b | input | ADDR_W | Byte base address of buffer B |
| buf_bytes | input | SIZE_W | Shared buffer size in bytes (multiple of 64) |
| irq_en_a | input | 1 | Interrupt enable for buffer A |
| irq_en_b | input | 1 | Interrupt enable for buffer B |
| ack_a | input | 1 | Refill acknowledge pulse for buffer A |
| ack_b | input | 1 | Refill acknowledge pulse for buffer B |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_gnt | input | 1 | Memory grant for the current request |
| rd_data | input | DATA_W | Read data, valid one cycle after grant |
| tx_valid | output | 1 | Word available to the serializer |
| tx_data | output | DATA_W | Word to the serializer |
| tx_ready | input | 1 | Serializer accepts the word |
| active_a | output | 1 | Buffer A is being read |
| active_b | output | 1 | Buffer B is being read |
| empty_a | output | 1 | Buffer A used up, awaiting acknowledge |
| empty_b | output | 1 | Buffer B used up, awaiting acknowledge |
| underrun | output | 1 | Sticky: sequencer stalled on an empty buffer |
| irq_a | output | 1 | Interrupt request for buffer A |
| irq_b | output | 1 | Interrupt request for buffer B |

## Verification
The bench runs buffer sizes of 16, 32 and 48 words under several ready and grant throttling patterns. It follows the stream across several swaps between the two buffers. A design with an off-by-one in the word count, or with a wrong offset reset at a swap, would send a word from the wrong address. Directed tests let both buffers run empty without acknowledges. A design without the stall would resend old data or keep issuing reads, and an underrun flag that is not sticky would drop while the stall goes on. The directed tests also mask one interrupt and leave the other enabled, and they turn the enable off in the middle of a buffer. A design that rewound badly would restart at buffer B or at a non-zero offset, and one that cleared the empty flags on disable would lose a pending refill request.

// File: rtl/pingpong_seq_pkg.sv
package pingpong_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_GATE = 3'd1,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd3,
        ST_SEND = 3'd4
    } seq_state_e;

    localparam int NUM_BUFS = 2;

endpackage

// File: rtl/pp_buf_flag.sv
module pp_buf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic irq_en_i,
    output logic empty_o,
    output logic irq_o
);

    logic empty_d, empty_q;

    always_comb begin
        empty_d = empty_q;
        if (ack_i) begin
            empty_d = 1'b0;
        end
        if (set_i) begin
            empty_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
        end else begin
            empty_q <= empty_d;
        end
    end

    assign empty_o = empty_q;
    assign irq_o   = empty_q & irq_en_i;

endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] base_a_i,
    input  logic [ADDR_W-1:0] base_b_i,
    input  logic              sel_i,
    input  logic [SIZE_W-1:0] off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int CMP_W = SIZE_W + 1;

    logic [CMP_W-1:0] next_off;

    always_comb begin
        next_off = {1'b0, off_i} + CMP_W'(STEP);
        last_o   = next_off >= {1'b0, size_i};
        addr_o   = (sel_i ? base_b_i : base_a_i) + ADDR_W'(off_i);
    end

endmodule

// File: rtl/pingpong_seq.sv
module pingpong_seq
    import pingpong_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic [ADDR_W-1:0] base_addr_a,
    input  logic [ADDR_W-1:0] base_addr_b,
    input  logic [SIZE_W-1:0] buf_bytes,
    input  logic              irq_en_a,
    input  logic              irq_en_b,
    input  logic              ack_a,
    input  logic              ack_b,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_gnt,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              active_a,
    output logic              active_b,
    output logic              empty_a,
    output logic              empty_b,
    output logic              underrun,
    output logic              irq_a,
    output logic              irq_b
);

    localparam int WORD_BYTES = DATA_W / 8;

    typedef struct packed {
        seq_state_e            st;
        logic                  sel;
        logic [SIZE_W-1:0]     off;
        logic [DATA_W-1:0]     data;
        logic [NUM_BUFS-1:0]   act;
        logic                  under;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                  is_last;
    logic                  buf_done;
    logic [NUM_BUFS-1:0]   set_vec;
    logic [NUM_BUFS-1:0]   ack_vec;
    logic [NUM_BUFS-1:0]   ien_vec;
    logic [NUM_BUFS-1:0]   empty_vec;
    logic [NUM_BUFS-1:0]   irq_vec;

    pp_addr_gen #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .STEP   (WORD_BYTES)
    ) u_addr (
        .base_a_i (base_addr_a),
        .base_b_i (base_addr_b),
        .sel_i    (seq_q.sel),
        .off_i    (seq_q.off),
        .size_i   (buf_bytes),
        .addr_o   (rd_addr),
        .last_o   (is_last)
    );

    assign ack_vec = {ack_b, ack_a};
    assign ien_vec = {irq_en_b, irq_en_a};

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_flag
        assign set_vec[g] = buf_done && (seq_q.sel == 1'(g));
        pp_buf_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[g]),
            .ack_i    (ack_vec[g]),
            .irq_en_i (ien_vec[g]),
            .empty_o  (empty_vec[g]),
            .irq_o    (irq_vec[g])
        );
    end

    always_comb begin
        seq_d    = seq_q;
        buf_done = 1'b0;
        if (!tx_enable) begin
            seq_d.st    = ST_IDLE;
            seq_d.sel   = 1'b0;
            seq_d.off   = '0;
            seq_d.act   = '0;
            seq_d.under = 1'b0;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    seq_d.st = ST_GATE;
                end
                ST_GATE: begin
                    if (empty_vec[seq_q.sel]) begin
                        seq_d.under = 1'b1;
                    end else begin
                        seq_d.st             = ST_REQ;
                        seq_d.act[seq_q.sel] = 1'b1;
                    end
                end
                ST_REQ: begin
                    if (rd_gnt) begin
                        seq_d.st = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    seq_d.data = rd_data;
                    seq_d.st   = ST_SEND;
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        if (is_last) begin
                            buf_done             = 1'b1;
                            seq_d.act[seq_q.sel] = 1'b0;
                            seq_d.sel            = ~seq_q.sel;
                            seq_d.off            = '0;
                            seq_d.st             = ST_GATE;
                        end else begin
                            seq_d.off = seq_q.off + SIZE_W'(WORD_BYTES);
                            seq_d.st  = ST_REQ;
                        end
                    end
                end
                default: begin
                    seq_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, sel: 1'b0, off: '0, data: '0, act: '0, under: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_req   = (seq_q.st == ST_REQ);
    assign tx_valid = (seq_q.st == ST_SEND);
    assign tx_data  = seq_q.data;
    assign active_a = seq_q.act[0];
    assign active_b = seq_q.act[1];
    assign empty_a  = empty_vec[0];
    assign empty_b  = empty_vec[1];
    assign irq_a    = irq_vec[0];
    assign irq_b    = irq_vec[1];
    assign underrun = seq_q.under;

endmodule

// File: rtl/pingpong_seq_chk.sv
module pingpong_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_enable,
    input logic              irq_en_a,
    input logic              irq_en_b,
    input logic              ack_a,
    input logic              ack_b,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_gnt,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              active_a,
    input logic              active_b,
    input logic              empty_a,
    input logic              empty_b,
    input logic              underrun,
    input logic              irq_a,
    input logic              irq_b
);

    a_r3_excl_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_a && empty_a));
    a_r3_excl_b: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_b && empty_b));

    a_r5_irq_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_a && irq_en_a) |-> irq_a);
    a_r5_irq_mask_b: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_b |-> !irq_b);

    a_r6_ack_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_a && !active_a) |=> !empty_a);
    a_r6_ack_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_b && !active_b) |=> !empty_b);

    a_r8_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && underrun) |=> underrun);

    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (!active_a && !active_b && !rd_req && !tx_valid && !underrun));
    a_r9_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !ack_a) |=> $stable(empty_a));
    a_r9_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !ack_b) |=> $stable(empty_b));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n || !tx_enable)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && tx_valid));

    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n || !tx_enable)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind pingpong_seq pingpong_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .irq_en_a  (irq_en_a),
    .irq_en_b  (irq_en_b),
    .ack_a     (ack_a),
    .ack_b     (ack_b),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_gnt    (rd_gnt),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .active_a  (active_a),
    .active_b  (active_b),
    .empty_a   (empty_a),
    .empty_b   (empty_b),
    .underrun  (underrun),
    .irq_a     (irq_a),
    .irq_b     (irq_b)
);

// File: tb/pingpong_seq_test.sv
module pingpong_seq_test;

    localparam logic [31:0] BASE_A = 32'h1000_0000;
    localparam logic [31:0] BASE_B = 32'h2000_0400;

    // {size bytes[35:20], ready mode[19:18], grant mode[17:16], words[15:0]}
    localparam logic [35:0] VEC [0:5] = '{
        {16'd64,  2'd0, 2'd0, 16'd40},
        {16'd64,  2'd1, 2'd0, 16'd40},
        {16'd128, 2'd0, 2'd1, 16'd80},
        {16'd192, 2'd2, 2'd2, 16'd100},
        {16'd64,  2'd2, 2'd0, 16'd50},
        {16'd128, 2'd1, 2'd2, 16'd70}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b0;
    logic [31:0] base_addr_a = BASE_A;
    logic [31:0] base_addr_b = BASE_B;
    logic [15:0] buf_bytes = 16'd64;
    logic        irq_en_a = 1'b1;
    logic        irq_en_b = 1'b1;
    logic        ack_a, ack_b;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_gnt = 1'b1;
    logic [31:0] rd_data = '0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_ready = 1'b1;
    logic        active_a, active_b, empty_a, empty_b, underrun, irq_a, irq_b;

    logic        auto_en_a = 1'b0, auto_en_b = 1'b0;
    logic        auto_ack_a = 1'b0, auto_ack_b = 1'b0;
    logic        man_ack_a = 1'b0, man_ack_b = 1'b0;
    logic [1:0]  rdy_mode = 2'd0, gnt_mode = 2'd0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] cyc = 0;

    int n_chk = 0, n_fail = 0;
    int words = 0, words_all = 0, grants = 0, r10_bad = 0, r11_bad = 0;
    bit mon_on = 1'b0;
    bit hold_pend = 1'b0;
    logic [31:0] hold_data = '0;

    assign ack_a = auto_ack_a | man_ack_a;
    assign ack_b = auto_ack_b | man_ack_b;

    always #5 clk = ~clk;

    pingpong_seq uut (
        .clk (clk), .rst_n (rst_n), .tx_enable (tx_enable),
        .base_addr_a (base_addr_a), .base_addr_b (base_addr_b), .buf_bytes (buf_bytes),
        .irq_en_a (irq_en_a), .irq_en_b (irq_en_b), .ack_a (ack_a), .ack_b (ack_b),
        .rd_req (rd_req), .rd_addr (rd_addr), .rd_gnt (rd_gnt), .rd_data (rd_data),
        .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
        .active_a (active_a), .active_b (active_b), .empty_a (empty_a), .empty_b (empty_b),
        .underrun (underrun), .irq_a (irq_a), .irq_b (irq_b)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // memory model: data valid the cycle after grant
    initial forever begin
        @(posedge clk);
        if (rd_req && rd_gnt) rd_data <= pat(rd_addr);
    end

    // throttling and software auto-acknowledge, driven after each edge
    initial forever begin
        @(posedge clk);
        #1;
        cyc  = cyc + 1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = (rdy_mode == 2'd0) ? 1'b1 : (rdy_mode == 2'd1) ? cyc[0] : lfsr[0];
        rd_gnt   = (gnt_mode == 2'd0) ? 1'b1 : (gnt_mode == 2'd1) ? ~cyc[0] : lfsr[3];
        auto_ack_a = auto_en_a && empty_a;
        auto_ack_b = auto_en_b && empty_b;
    end

    // monitor, sampling at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (rd_req && rd_gnt) begin
                if (grants != words_all) r10_bad++;
                grants++;
            end
            if (hold_pend && !(tx_valid && tx_data == hold_data)) r11_bad++;
            hold_pend = tx_valid && !tx_ready && tx_enable;
            hold_data = tx_data;
            if (tx_valid && tx_ready) begin
                words_all++;
                if (mon_on) begin
                    int w, b;
                    logic [31:0] ea;
                    w  = int'(buf_bytes) / 4;
                    b  = (words / w) % 2;
                    ea = (b == 1 ? base_addr_b : base_addr_a) + 32'((words % w) * 4);
                    chk(tx_data == pat(ea), b == 1 ? "R4 word from buffer B" : "R2 word from buffer A",
                        tx_data, pat(ea));
                end
                words++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    task automatic wait_words(input int n, input string req);
        int t = 0;
        while (words < n && t < 20000) begin
            tick();
            t++;
        end
        chk(words >= n, req, 32'(words), 32'(n));
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({rd_req, tx_valid, active_a, active_b, empty_a, empty_b, underrun, irq_a, irq_b} == 9'b0,
            "R1 reset outputs",
            32'({rd_req, tx_valid, active_a, active_b, empty_a, empty_b, underrun, irq_a, irq_b}), 32'd0);
        tick();

        // vector table: sizes and throttling patterns, continuous auto-ack
        for (int v = 0; v < 6; v++) begin
            tx_enable = 1'b0;
            tick(2);
            buf_bytes = VEC[v][35:20];
            rdy_mode  = VEC[v][19:18];
            gnt_mode  = VEC[v][17:16];
            auto_en_a = 1'b1;
            auto_en_b = 1'b1;
            tick(3);
            words = 0; words_all = 0; grants = 0; r10_bad = 0; r11_bad = 0;
            mon_on = 1'b1;
            tx_enable = 1'b1;
            wait_words(int'(VEC[v][15:0]), "R4 stream progress");
            chk(r10_bad == 0, "R10 single outstanding read", 32'(r10_bad), 32'd0);
            chk(r11_bad == 0, "R11 tx hold under backpressure", 32'(r11_bad), 32'd0);
            tx_enable = 1'b0;
            mon_on = 1'b0;
        end

        // directed: no acknowledges, masked irq on A, stall
        tick(2);
        rdy_mode = 2'd0; gnt_mode = 2'd0;
        buf_bytes = 16'd64;
        tick(3);
        auto_en_a = 1'b0; auto_en_b = 1'b0;
        irq_en_a = 1'b0; irq_en_b = 1'b1;
        tick(2);
        words = 0; mon_on = 1'b1;
        tx_enable = 1'b1;
        for (int t = 0; t < 3000 && !empty_a; t++) @(negedge clk);
        chk(words == 16, "R3 words in buffer A before empty", 32'(words), 32'd16);
        chk(!active_a, "R3 active_a low after last word", 32'(active_a), 32'd0);
        chk(!irq_a, "R5 irq_a masked", 32'(irq_a), 32'd0);
        tick(3);
        chk(active_b, "R4 buffer B active after A", 32'(active_b), 32'd1);
        for (int t = 0; t < 3000 && !empty_b; t++) @(negedge clk);
        chk(words == 32, "R3 words in buffer B before empty", 32'(words), 32'd32);
        chk(irq_b, "R5 irq_b raised", 32'(irq_b), 32'd1);
        tick(5);
        chk(underrun, "R7 underrun on empty buffer", 32'(underrun), 32'd1);
        chk(!rd_req && !tx_valid, "R7 no traffic while stalled", 32'({rd_req, tx_valid}), 32'd0);
        tick(20);
        chk(underrun && words == 32, "R8 underrun sticky, still stalled", 32'(words), 32'd32);

        // disable keeps empty flags, clears underrun and activity
        tx_enable = 1'b0;
        tick(2);
        chk(empty_a && empty_b, "R9 empty flags kept on disable", 32'({empty_a, empty_b}), 32'h3);
        chk(!underrun, "R8 underrun cleared by disable", 32'(underrun), 32'd0);
        chk(!active_a && !active_b, "R9 active flags cleared", 32'({active_a, active_b}), 32'd0);

        // manual acknowledge of B
        man_ack_b = 1'b1;
        tick();
        man_ack_b = 1'b0;
        @(negedge clk);
        chk(!empty_b && !irq_b, "R6 ack_b clears flag and irq", 32'({empty_b, irq_b}), 32'd0);
        chk(empty_a, "R6 ack_b leaves empty_a", 32'(empty_a), 32'd1);

        // re-enable with A still empty: stall, then resume at A offset 0
        tick();
        words = 0;
        tx_enable = 1'b1;
        tick(6);
        chk(underrun && !tx_valid, "R7 stall at buffer A", 32'(underrun), 32'd1);
        man_ack_a = 1'b1;
        tick();
        man_ack_a = 1'b0;
        auto_en_a = 1'b1; auto_en_b = 1'b1;
        wait_words(20, "R7 resume after acknowledge");

        // disable mid buffer B, restart must be buffer A offset 0
        tx_enable = 1'b0;
        tick(3);
        words = 0;
        tx_enable = 1'b1;
        wait_words(5, "R9 restart at buffer A");
        tx_enable = 1'b0;
        tick(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule